// File: doc/BRIEF.md
# Card Detect Latch Register Block

This block is a small register window that reports the state of a removable memory card slot to software and raises an interrupt when a card is seen. Two plain inputs come from the slot: a write-protect level and a card-present level. A status word combines a live copy of the write-protect level with a sticky card-present flag. The flag also drives the interrupt output. Software acknowledges the event by writing a 1 to the flag's bit position in the status word.

The register window has four word slots. Slot 0 returns a fixed identity word. Slot 1 is a flash programming control that reads zero and ignores writes. Slot 2 is the status word. Slot 3 returns a fixed decode word and ignores writes. Any other slot, and any write to the identity slot, is reported as an error. The error response carries zero read data. Accesses use a single-cycle strobe with no back-pressure: the block accepts every strobe and answers exactly one cycle later. Control and status pins are plain levels.

Top module: `card_detect_regs`

## Requirements
- R1: After reset the status word reads 0x00000000, `card_irq` is low, and `rsp_valid` is low until an access is made.
- R2: Reads at slot 0 return 0x41034003, at slot 1 return 0x00000000 and at slot 3 return 0x00000011, all with `rsp_err` low.
- R3: Status bit 0 follows `wp_in` live: one cycle after `wp_in` changes, the read value of bit 0 equals the new level.
- R4: A high `cd_in` sets status bit 3 on the next clock edge, and `card_irq` rises on that same edge.
- R5: A low `cd_in` never clears status bit 3. Only a clear write can clear it.
- R6: A write at slot 2 clears bit 3 and drops `card_irq` only when write data bit 3 is 1. Write data with bit 3 at 0 has no effect. No other bit is writable, and bit 0 keeps following `wp_in`.
- R7: If `cd_in` is high on the same edge as a clearing write, the set wins and bit 3 stays 1.
- R8: Writes at slots 1 and 3 complete with `rsp_err` low and change no state. A write at slot 0 completes with `rsp_err` high and changes no state.
- R9: Any access at a slot index of 4 or more completes with `rsp_err` high and read data 0, and a write there changes no state.
- R10: Status bits other than bits 0 and 3 always read as 0.
- R11: `rsp_valid` is high for exactly the one cycle that follows each `acc_req` cycle. Read data and the error flag are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_req | input | 1 | Access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_idx | input | IDX_W (6) | Word slot index |
| acc_wdata | input | DATA_W (32) | Write data |
| wp_in | input | 1 | Card write-protect level |
| cd_in | input | 1 | Card-present level |
| rsp_valid | output | 1 | Response valid, one cycle after `acc_req` |
| rsp_rdata | output | DATA_W (32) | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access error flag |
| card_irq | output | 1 | Interrupt, high while the card flag is set |

## Verification
Assertions watch the status register on every cycle. They check that the write-protect bit follows its input with one cycle of delay, that a high card input always sets the flag, and that the flag never drops unless a clearing write arrives while the input is low. They also check that a clear racing a set leaves the flag set, and that error responses carry zero data. The bench scenarios cover what single-cycle properties cannot show. These are the constant slot values, the rule that write data bits other than bit 3 are ignored, and that ignored and faulting writes leave the status unchanged. They also cover the zero unused bits and the exact cycle of each response.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

  // Slot selector taken from the two low bits of a known word index.
  typedef enum logic [1:0] {
    SEL_IDENT  = 2'd0,
    SEL_PROG   = 2'd1,
    SEL_STAT   = 2'd2,
    SEL_DECODE = 2'd3
  } reg_sel_e;

  // Decoded access, produced by the decoder and consumed by the responder.
  typedef struct packed {
    logic     known;    // index lies inside the register window
    reg_sel_e sel;      // which slot
    logic     bad;      // access must be answered with an error
    logic     clr_stb;  // legal write to the status slot
  } dec_t;

  localparam int unsigned NUM_SLOTS = 4;

endpackage

// File: rtl/cdl_decode.sv
module cdl_decode
  import cdl_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             req,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  output dec_t             dec
);

  localparam logic [IDX_W-1:0] SLOT_LIMIT = IDX_W'(NUM_SLOTS);

  logic     in_window;
  reg_sel_e slot;
  logic     ro_write;

  always_comb begin
    in_window = (idx < SLOT_LIMIT);
    slot      = reg_sel_e'(idx[1:0]);
    // The identity slot has no write side; prog and decode swallow writes.
    ro_write  = we && (slot == SEL_IDENT);

    dec.known   = in_window;
    dec.sel     = slot;
    dec.bad     = req && (!in_window || ro_write);
    dec.clr_stb = req && we && in_window && (slot == SEL_STAT);
  end

endmodule

// File: rtl/cdl_status.sv
module cdl_status #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WP_POS = 0,
  parameter int unsigned CD_POS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_in,
  input  logic              cd_in,
  input  logic              clr_stb,
  input  logic [DATA_W-1:0] clr_data,
  output logic [DATA_W-1:0] status,
  output logic              cd_flag
);

  logic wp_q;
  logic cd_q;
  logic clr_hit;

  assign clr_hit = clr_stb && clr_data[CD_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= 1'b0;
      cd_q <= 1'b0;
    end else begin
      wp_q <= wp_in;
      // Set has priority over a clear landing on the same edge.
      cd_q <= cd_in || (cd_q && !clr_hit);
    end
  end

  // Assemble the status word; every other bit is tied low.
  for (genvar b = 0; b < DATA_W; b++) begin : g_stat_bit
    if (b == WP_POS) begin : g_wp
      assign status[b] = wp_q;
    end else if (b == CD_POS) begin : g_cd
      assign status[b] = cd_q;
    end else begin : g_zero
      assign status[b] = 1'b0;
    end
  end

  assign cd_flag = cd_q;

  assert_wp_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status[WP_POS] == $past(wp_in)));

  assert_cd_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cd_in |=> status[CD_POS]);

  assert_cd_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[CD_POS] && !(clr_stb && clr_data[CD_POS])) |=> status[CD_POS]);

  assert_cd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && clr_data[CD_POS] && !cd_in) |=> !status[CD_POS]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && clr_data[CD_POS] && cd_in) |=> status[CD_POS]);

endmodule

// File: rtl/cdl_resp.sv
module cdl_resp
  import cdl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter logic [DATA_W-1:0] ID_WORD  = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DEC_WORD = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  dec_t              dec,
  input  logic [DATA_W-1:0] status,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  logic [DATA_W-1:0] slot_val;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    unique case (dec.sel)
      SEL_IDENT:  slot_val = ID_WORD;
      SEL_PROG:   slot_val = '0;
      SEL_STAT:   slot_val = status;
      SEL_DECODE: slot_val = DEC_WORD;
      default:    slot_val = '0;
    endcase
    rd_next = (req && !we && dec.known) ? slot_val : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req;
      rsp_rdata <= rd_next;
      rsp_err   <= dec.bad;
    end
  end

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

  assert_rsp_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !req) |=> !rsp_valid);

endmodule

// File: rtl/card_detect_regs.sv
module card_detect_regs
  import cdl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned WP_POS = 0,
  parameter int unsigned CD_POS = 3,
  parameter logic [DATA_W-1:0] ID_WORD  = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DEC_WORD = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              wp_in,
  input  logic              cd_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              card_irq
);

  dec_t              dec;
  logic [DATA_W-1:0] status;
  logic              cd_flag;

  cdl_decode #(.IDX_W(IDX_W)) u_decode (
    .req (acc_req),
    .we  (acc_we),
    .idx (acc_idx),
    .dec (dec)
  );

  cdl_status #(
    .DATA_W (DATA_W),
    .WP_POS (WP_POS),
    .CD_POS (CD_POS)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_in    (wp_in),
    .cd_in    (cd_in),
    .clr_stb  (dec.clr_stb),
    .clr_data (acc_wdata),
    .status   (status),
    .cd_flag  (cd_flag)
  );

  cdl_resp #(
    .DATA_W   (DATA_W),
    .ID_WORD  (ID_WORD),
    .DEC_WORD (DEC_WORD)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (acc_req),
    .we        (acc_we),
    .dec       (dec),
    .status    (status),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  assign card_irq = cd_flag;

endmodule

// File: tb/card_detect_regs_test.sv
module card_detect_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_req = 1'b0;
  logic        acc_we = 1'b0;
  logic [5:0]  acc_idx = '0;
  logic [31:0] acc_wdata = '0;
  logic        wp_in = 1'b0;
  logic        cd_in = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        card_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] got_data;
  logic        got_err;
  logic        got_valid;

  always #2 clk = ~clk;

  card_detect_regs uut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .wp_in(wp_in), .cd_in(cd_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .card_irq(card_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // One access: drive at a falling edge, response sampled at the next one.
  task automatic access(input logic we, input logic [5:0] idx, input logic [31:0] wd);
    @(negedge clk);
    acc_req = 1'b1; acc_we = we; acc_idx = idx; acc_wdata = wd;
    @(negedge clk);
    acc_req = 1'b0; acc_we = 1'b0; acc_wdata = '0;
    got_data = rsp_rdata; got_err = rsp_err; got_valid = rsp_valid;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, card_irq}, 32'd0);
    chk("R1 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    access(1'b0, 6'd2, '0);
    chk("R1 status after reset", got_data, 32'h0);
    chk("R11 rsp_valid after access", {31'd0, got_valid}, 32'd1);
    @(negedge clk);
    chk("R11 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_ident;
    access(1'b0, 6'd0, '0);
    chk("R2 ident word", got_data, 32'h4103_4003);
    chk("R2 ident err", {31'd0, got_err}, 32'd0);
    access(1'b0, 6'd1, '0);
    chk("R2 prog reads zero", got_data, 32'h0);
    access(1'b0, 6'd3, '0);
    chk("R2 decode word", got_data, 32'h11);
    chk("R2 decode err", {31'd0, got_err}, 32'd0);
  endtask

  task automatic t_wp;
    @(negedge clk); wp_in = 1'b1;
    access(1'b0, 6'd2, '0);
    chk("R3 wp high", got_data, 32'h1);
    @(negedge clk); wp_in = 1'b0;
    access(1'b0, 6'd2, '0);
    chk("R3 wp low", got_data, 32'h0);
  endtask

  task automatic t_cd;
    @(negedge clk); cd_in = 1'b1;
    @(negedge clk); cd_in = 1'b0;
    chk("R4 irq on set edge", {31'd0, card_irq}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R5 irq held with low input", {31'd0, card_irq}, 32'd1);
    access(1'b0, 6'd2, '0);
    chk("R5 flag held", got_data, 32'h8);
  endtask

  task automatic t_clear;
    @(negedge clk); wp_in = 1'b1;
    access(1'b1, 6'd2, 32'h0000_0000);
    access(1'b0, 6'd2, '0);
    chk("R6 zero write no effect", got_data, 32'h9);
    access(1'b1, 6'd2, 32'hFFFF_FFF7);
    access(1'b0, 6'd2, '0);
    chk("R6 other bits ignored", got_data, 32'h9);
    access(1'b1, 6'd2, 32'h0000_0008);
    chk("R6 irq drops", {31'd0, card_irq}, 32'd0);
    access(1'b0, 6'd2, '0);
    chk("R6 flag cleared wp kept", got_data, 32'h1);
    @(negedge clk); wp_in = 1'b0;
  endtask

  task automatic t_setwins;
    @(negedge clk); cd_in = 1'b1;
    access(1'b1, 6'd2, 32'h8);
    @(negedge clk); cd_in = 1'b0;
    access(1'b0, 6'd2, '0);
    chk("R7 set beats clear", got_data, 32'h8);
    chk("R7 irq stays", {31'd0, card_irq}, 32'd1);
    access(1'b1, 6'd2, 32'h8);
    access(1'b0, 6'd2, '0);
    chk("R7 later clear works", got_data, 32'h0);
  endtask

  task automatic t_ignored;
    @(negedge clk); cd_in = 1'b1; wp_in = 1'b1;
    @(negedge clk); cd_in = 1'b0;
    access(1'b1, 6'd1, 32'hFFFF_FFFF);
    chk("R8 prog write err", {31'd0, got_err}, 32'd0);
    access(1'b1, 6'd3, 32'hFFFF_FFFF);
    chk("R8 decode write err", {31'd0, got_err}, 32'd0);
    access(1'b1, 6'd0, 32'hFFFF_FFFF);
    chk("R8 ident write err", {31'd0, got_err}, 32'd1);
    access(1'b0, 6'd2, '0);
    chk("R8 status unchanged", got_data, 32'h9);
    chk("R10 unused bits zero", got_data & 32'hFFFF_FFF6, 32'h0);
    access(1'b0, 6'd0, '0);
    chk("R8 ident unchanged", got_data, 32'h4103_4003);
    access(1'b0, 6'd3, '0);
    chk("R8 decode unchanged", got_data, 32'h11);
  endtask

  task automatic t_bad;
    access(1'b0, 6'd5, '0);
    chk("R9 out-of-window read data", got_data, 32'h0);
    chk("R9 out-of-window read err", {31'd0, got_err}, 32'd1);
    access(1'b1, 6'd6, 32'h8);
    chk("R9 out-of-window write err", {31'd0, got_err}, 32'd1);
    access(1'b1, 6'd63, 32'hFFFF_FFFF);
    chk("R9 top index write err", {31'd0, got_err}, 32'd1);
    access(1'b0, 6'd2, '0);
    chk("R9 status untouched", got_data, 32'h9);
    chk("R9 irq untouched", {31'd0, card_irq}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ident();
    t_wp();
    t_cd();
    t_clear();
    t_setwins();
    t_ignored();
    t_bad();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule